// File: doc/BRIEF.md
# Serial/Parallel FIFO Entry Register

This block is the write-side staging register of a cascadable FIFO slice. A word enters either all at once, captured while a parallel load strobe is high, or one bit at a time on the falling edges of a serial clock. A marker bit travels through a chain one stage longer than the word. When the marker reaches the last stage the register is full, and an active-low full flag drops.

While the transfer request is low and the stack reports a free top slot, the held word is pushed into the stack with a one-cycle valid pulse. A request latch remembers that the word has gone, so a request held low cannot push it a second time. The register is then cleared. Clearing waits while the load strobe is still high.

A role latch makes the slice a row master or a slave. A master clears at once. A slave clears only after its serial-enable input goes low, so that clearing ripples along a row of slices. If the full flag is looped back to the transfer input, the block pushes each word by itself as soon as it is complete. All logic runs on one system clock. The serial clock passes through a synchronizer before its falling edges are detected.

Top module: `fifo_entry_reg`

## Requirements
- R1: While reset is low and on release, `full_no` is 1 and `push_o` is 0. At the first clock after release, `ser_en_ni` sets the role: 0 selects master and 1 selects slave.
- R2: At each clock where `load_i` is 1, `data_i` is captured into the word and the register becomes full. From the next cycle `full_no` is 0 and `push_data_o` equals the captured value.
- R3: Each falling edge of `ser_clk_i` shifts in one bit while `ser_en_ni` and `load_i` are 0. The shift completes within SYNC_STAGES+1 clocks. The first serial bit ends up in bit 0 of the word and the WIDTH-th bit ends up in bit WIDTH-1. After WIDTH edges, and not before, `full_no` goes to 0.
- R4: While the register is full, serial clock edges leave the word and `full_no` unchanged.
- R5: `push_o` is 1 only in a cycle where the register is full, `xfer_ni` is 0, `push_ready_i` is 1 and the current word has not yet been pushed. `push_data_o` then carries the word. If `push_ready_i` is 0, no push happens.
- R6: Each word causes exactly one single-cycle push, even when `xfer_ni` stays low.
- R7: After a push, clearing waits while `load_i` is 1. Once `load_i` is 0, a master clears, so `full_no` returns to 1 one clock later.
- R8: A slave that has pushed stays full, and does not push again, until `ser_en_ni` is 0. It clears at the next clock after that.
- R9: With `full_no` fed back to `xfer_ni`, consecutive serial words are each pushed once, with their correct values, and no other control is needed.
- R10: While `ser_en_ni` is 1, serial clock edges shift nothing into an empty register, and `full_no` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset; initializes control and chain |
| load_i | input | 1 | Parallel load strobe, level sensitive |
| data_i | input | WIDTH | Parallel word |
| ser_clk_i | input | 1 | Serial clock, falling edge active |
| ser_d_i | input | 1 | Serial data bit |
| ser_en_ni | input | 1 | Active-low serial enable and row interlock |
| xfer_ni | input | 1 | Active-low transfer request |
| push_ready_i | input | 1 | Stack top slot free |
| push_o | output | 1 | Push valid to stack |
| push_data_o | output | WIDTH | Word presented to the stack |
| full_no | output | 1 | Active-low register full flag |

## Verification
The properties assume that `ser_clk_i` and `ser_d_i` each stay at one level for longer than the synchronizer depth. They also assume that `ser_d_i` does not change while a falling edge is passing through the synchronizer, and that a slave's role is not changed after reset. The bench respects these assumptions. It changes every input only on the falling system-clock edge, holds each serial clock phase for four system cycles, and sets the role only while reset is low. Under those conditions the properties check five things: a load always leaves the register full with the loaded word, a push is never repeated in the next cycle, a held load keeps the register full, a gated serial clock never fills an empty register, and reset release leaves the flag high.

// File: rtl/fifo_entry_pkg.sv
package fifo_entry_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_LOAD,
    ACT_INIT,
    ACT_SHIFT
  } chain_act_e;
endpackage

// File: rtl/fifo_entry_sclk.sv
module fifo_entry_sclk #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_clk_i,
  input  logic ser_d_i,
  output logic fall_o,
  output logic bit_o
);
  logic [1:0] stg_q [SYNC_STAGES];
  logic       prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= {ser_clk_i, ser_d_i};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= stg_q[SYNC_STAGES-1][1];

  assign fall_o = prev_q & ~stg_q[SYNC_STAGES-1][1];
  assign bit_o  = stg_q[SYNC_STAGES-1][0];
endmodule

// File: rtl/fifo_entry_ctrl.sv
module fifo_entry_ctrl
  import fifo_entry_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       ser_en_ni,
  input  logic       xfer_ni,
  input  logic       push_ready_i,
  input  logic       full_i,
  input  logic       fall_i,
  output logic       push_o,
  output chain_act_e act_o
);
  logic armed_q, master_q, req_q;
  logic take, do_init;

  assign take    = full_i & ~xfer_ni & ~req_q & push_ready_i;
  assign do_init = req_q & ~load_i & (master_q | ~ser_en_ni);
  assign push_o  = take;

  always_comb begin
    if (load_i)                             act_o = ACT_LOAD;
    else if (do_init)                       act_o = ACT_INIT;
    else if (fall_i && !ser_en_ni && !full_i) act_o = ACT_SHIFT;
    else                                    act_o = ACT_HOLD;
  end

  // role sampled once, at the first clock after reset release
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      master_q <= 1'b0;
    end else if (!armed_q) begin
      armed_q  <= 1'b1;
      master_q <= ~ser_en_ni;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      req_q <= 1'b0;
    else if (take)    req_q <= 1'b1;
    else if (do_init) req_q <= 1'b0;
endmodule

// File: rtl/fifo_entry_chain.sv
module fifo_entry_chain
  import fifo_entry_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  chain_act_e       act_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             bit_i,
  output logic             full_o,
  output logic [WIDTH-1:0] word_o
);
  localparam int CHAIN = WIDTH + 1;
  localparam logic [CHAIN-1:0] INIT_VEC = {1'b1, {WIDTH{1'b0}}};

  // [0] is the full marker stage, [WIDTH:1] hold the word
  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) chain_q <= INIT_VEC;
    else begin
      unique case (act_i)
        ACT_LOAD:  chain_q <= {data_i, 1'b1};
        ACT_INIT:  chain_q <= INIT_VEC;
        ACT_SHIFT: chain_q <= {bit_i, chain_q[CHAIN-1:1]};
        default:   chain_q <= chain_q;
      endcase
    end

  assign full_o = chain_q[0];
  assign word_o = chain_q[CHAIN-1:1];
endmodule

// File: rtl/fifo_entry_reg.sv
module fifo_entry_reg
  import fifo_entry_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             ser_clk_i,
  input  logic             ser_d_i,
  input  logic             ser_en_ni,
  input  logic             xfer_ni,
  input  logic             push_ready_i,
  output logic             push_o,
  output logic [WIDTH-1:0] push_data_o,
  output logic             full_no
);
  logic       fall, sbit, full;
  chain_act_e act;

  fifo_entry_sclk #(.SYNC_STAGES(SYNC_STAGES)) u_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_clk_i(ser_clk_i), .ser_d_i(ser_d_i),
    .fall_o(fall), .bit_o(sbit)
  );

  fifo_entry_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .ser_en_ni(ser_en_ni),
    .xfer_ni(xfer_ni), .push_ready_i(push_ready_i), .full_i(full),
    .fall_i(fall), .push_o(push_o), .act_o(act)
  );

  fifo_entry_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .data_i(data_i),
    .bit_i(sbit), .full_o(full), .word_o(push_data_o)
  );

  assign full_no = ~full;
endmodule

// File: rtl/fifo_entry_reg_chk.sv
module fifo_entry_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [WIDTH-1:0] data_i,
  input logic             ser_en_ni,
  input logic             push_o,
  input logic [WIDTH-1:0] push_data_o,
  input logic             full_no
);
  a_r1_reset_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (full_no && !push_o));

  a_r2_load_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!full_no && push_data_o == $past(data_i)));

  a_r6_single_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> (!push_o && !full_no));

  a_r7_load_blocks_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && load_i) |=> !full_no);

  a_r10_gated_serial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_no && !load_i && ser_en_ni) |=> full_no);
endmodule

bind fifo_entry_reg fifo_entry_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .data_i(data_i),
  .ser_en_ni(ser_en_ni), .push_o(push_o), .push_data_o(push_data_o),
  .full_no(full_no)
);

// File: tb/fifo_entry_reg_tb.sv
module fifo_entry_reg_tb;
  localparam int WIDTH = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0;
  logic [WIDTH-1:0] data_i = '0;
  logic ser_clk_i = 1'b0, ser_d_i = 1'b0, ser_en_ni = 1'b0;
  logic xfer_drv = 1'b1, auto_mode = 1'b0, push_ready_i = 1'b1;
  logic xfer_ni;
  logic push_o, full_no;
  logic [WIDTH-1:0] push_data_o;

  int checks = 0, fails = 0, push_cnt = 0;
  logic [WIDTH-1:0] last_push = '0;

  always #2 clk = ~clk;

  assign xfer_ni = auto_mode ? full_no : xfer_drv;

  fifo_entry_reg #(.WIDTH(WIDTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .data_i(data_i),
    .ser_clk_i(ser_clk_i), .ser_d_i(ser_d_i), .ser_en_ni(ser_en_ni),
    .xfer_ni(xfer_ni), .push_ready_i(push_ready_i), .push_o(push_o),
    .push_data_o(push_data_o), .full_no(full_no)
  );

  // push monitor: samples just before the accepting edge
  always @(negedge clk) begin
    #1;
    if (rst_ni && push_o) begin
      push_cnt++;
      last_push = push_data_o;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset(logic slave);
    @(negedge clk);
    rst_ni = 1'b0; ser_en_ni = slave; load_i = 1'b0; xfer_drv = 1'b1;
    auto_mode = 1'b0; ser_clk_i = 1'b0;
    cyc(3);
    check("R1 full_no in reset", full_no, 1);
    @(negedge clk);
    rst_ni = 1'b1;
    cyc(2);
  endtask

  task automatic ser_bit(logic b);
    @(negedge clk);
    ser_d_i = b; ser_clk_i = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk_i = 1'b0;
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    check("R1 full_no after reset", full_no, 1);
    check("R1 push_o after reset", push_o, 0);
  endtask

  task automatic t_parallel();
    int base;
    @(negedge clk); data_i = 4'hA; load_i = 1'b1;
    @(negedge clk); load_i = 1'b0; data_i = 4'h3; #1;
    check("R2 full after load", full_no, 0);
    check("R2 loaded word", push_data_o, 4'hA);
    ser_bit(1'b0); ser_bit(1'b1);
    check("R4 word kept while full", push_data_o, 4'hA);
    check("R4 still full", full_no, 0);
    base = push_cnt;
    @(negedge clk); push_ready_i = 1'b0; xfer_drv = 1'b0;
    cyc(4);
    check("R5 no push while stack busy", push_cnt, base);
    @(negedge clk); push_ready_i = 1'b1;
    cyc(6);
    check("R6 single push with xfer held", push_cnt, base + 1);
    check("R5 pushed word", last_push, 4'hA);
    check("R7 master cleared", full_no, 1);
    @(negedge clk); xfer_drv = 1'b1;
  endtask

  task automatic t_postpone();
    int base = push_cnt;
    @(negedge clk); data_i = 4'hB; load_i = 1'b1;
    @(negedge clk); xfer_drv = 1'b0;
    cyc(5);
    check("R7 full while load high", full_no, 0);
    check("R6 one push during load", push_cnt, base + 1);
    @(negedge clk); load_i = 1'b0;
    cyc(1);
    check("R7 cleared after load low", full_no, 1);
    check("R7 no extra push", push_cnt, base + 1);
    @(negedge clk); xfer_drv = 1'b1;
  endtask

  task automatic t_serial();
    int base = push_cnt;
    ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
    check("R3 not full after 3 bits", full_no, 1);
    ser_bit(1'b1);
    check("R3 full after 4 bits", full_no, 0);
    check("R3 serial word order", push_data_o, 4'hD);
    @(negedge clk); xfer_drv = 1'b0;
    cyc(3);
    check("R5 serial word pushed", last_push, 4'hD);
    check("R6 serial push count", push_cnt, base + 1);
    @(negedge clk); xfer_drv = 1'b1;
  endtask

  task automatic t_gated();
    @(negedge clk); ser_en_ni = 1'b1;
    ser_bit(1'b1); ser_bit(1'b1); ser_bit(1'b1); ser_bit(1'b1);
    check("R10 gated serial stays empty", full_no, 1);
    @(negedge clk); ser_en_ni = 1'b0;
    ser_bit(1'b0); ser_bit(1'b1); ser_bit(1'b1);
    check("R10 no residue, 3 bits not full", full_no, 1);
    ser_bit(1'b0);
    check("R10 word from enabled bits only", push_data_o, 4'h6);
    @(negedge clk); xfer_drv = 1'b0;
    cyc(3);
    @(negedge clk); xfer_drv = 1'b1;
  endtask

  task automatic t_auto();
    int base = push_cnt;
    @(negedge clk); auto_mode = 1'b1;
    ser_bit(1'b0); ser_bit(1'b1); ser_bit(1'b1); ser_bit(1'b0);
    cyc(2);
    check("R9 first auto push", push_cnt, base + 1);
    check("R9 first auto word", last_push, 4'h6);
    ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b0); ser_bit(1'b1);
    cyc(2);
    check("R9 second auto push", push_cnt, base + 2);
    check("R9 second auto word", last_push, 4'h9);
    check("R9 cleared after auto push", full_no, 1);
    @(negedge clk); auto_mode = 1'b0;
  endtask

  task automatic t_slave();
    int base;
    do_reset(1'b1);
    base = push_cnt;
    @(negedge clk); data_i = 4'h5; load_i = 1'b1;
    @(negedge clk); load_i = 1'b0; xfer_drv = 1'b0;
    cyc(6);
    check("R8 slave single push", push_cnt, base + 1);
    check("R8 slave pushed word", last_push, 4'h5);
    check("R8 slave holds until enable", full_no, 0);
    @(negedge clk); ser_en_ni = 1'b0;
    cyc(1);
    check("R8 slave cleared after enable low", full_no, 1);
    check("R8 no repeat push", push_cnt, base + 1);
    @(negedge clk); xfer_drv = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_parallel();
    t_postpone();
    t_serial();
    t_gated();
    t_auto();
    t_slave();
    cyc(2);
    finish_run();
  end
endmodule